// File: doc/BRIEF.md
# Receive Status Ring Writer

This block closes the receive side of a DMA engine. Each time the receive path finishes a frame, it raises a one-cycle frame-done event carrying the frame length and a set of error flags. The writer packs these into a two-word status entry and writes the entry into a circular ring in system memory through a 64-bit write port. It also sets an interrupt-pending bit that software clears by acknowledging it.

Software controls the ring through a small configuration write port. It sets the ring base address, the ring size in bytes, and the largest legal frame length. It hands back consumed slots by writing counts to two enqueue selectors. One selector is for status slots and one is for receive descriptors. A frame is recorded only while both credit pools are non-zero, and each recorded frame uses one credit from each pool. A frame that arrives with either pool empty is dropped and leaves no trace.

Top module: `rx_status_writer`

## Requirements
- R1: After reset, mem_we and irq_pend are low, both credit pools are empty, the ring holds MAX_ENTRIES entries from base 0, and the maximum length is DEF_MAX_LEN.
- R2: Word 0 (mem_wdata[31:0]) has bit 31 = 1, bit 29 = 1 (end of frame) and bit 28 = 1 (end of buffer). Bits 21..16 carry the error flags: 21 receive error, 20 overrun, 19 framing, 18 runt, 17 extra data, 16 CRC error. These come from fd_flags[5:0] in the same order. Bit 15 carries fd_flags[6] (CRC included). All other bits are 0.
- R3: Word 1 (mem_wdata[63:32]) has bit 31 = 1, bits 30:16 = the slot index and bits 15:0 = fd_len. Both words of every entry have bit 31 set.
- R4: An entry goes to base + 8 × slot, where slot starts at 0 and advances by one per written entry, wrapping modulo the ring entry count.
- R5: No entry is written while the status credit pool is zero. A status enqueue (cfg_sel 2) adds cfg_wdata[15:0] credits, and the pool saturates at the ring entry count.
- R6: No entry is written while the descriptor credit pool is zero. A descriptor enqueue (cfg_sel 3) behaves like a status enqueue. Each written entry takes one credit from each pool.
- R7: A frame whose length exceeds the maximum-length register (cfg_sel 4, cfg_wdata[15:0]) gets word 0 bit 17 set. A length equal to the maximum is not flagged.
- R8: Word 0 bit 30 (clean frame) is 1 exactly when bits 21..16 are all 0.
- R9: irq_pend is set in the cycle an entry is written. Otherwise, irq_ack clears it. A write and an ack in the same cycle leave it set.
- R10: A frame-done event accepted at one clock edge produces mem_we high in the following cycle. A configuration write takes effect from the next cycle, so a frame at the same edge as an enqueue still sees the old credit value.
- R11: Writing the ring base (cfg_sel 0) or the ring size in bytes (cfg_sel 1, entries = value / 8) returns the slot to 0 and empties both credit pools. A size of 0, or one above MAX_ENTRIES, selects MAX_ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fd_valid | input | 1 | Frame-done event |
| fd_len | input | 16 | Frame length in bytes |
| fd_flags | input | 7 | {crc_included, rx_err, overrun, framing, runt, extra, crc_err} |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 base, 1 ring bytes, 2 status enqueue, 3 descriptor enqueue, 4 max length |
| cfg_wdata | input | 32 | Configuration write data |
| irq_ack | input | 1 | Clears the interrupt-pending bit |
| irq_pend | output | 1 | Interrupt pending |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_wdata | output | 64 | {word1, word0} |

## Verification
Single frames with no error flags, with a single flag set, and with lengths on either side of the maximum tell the packing of word 0 apart from the derivation of the clean-frame bit. Back-to-back bursts longer than the credit pools separate the status-credit gate from the descriptor-credit gate and expose the exact frame at which drops begin. A shrunken ring with repeated enqueues drives the slot index around its wrap point. Acknowledges placed alone and in the same cycle as a write distinguish the two priorities of the interrupt bit.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic [2:0] {
      CFG_BASE       = 3'd0,
      CFG_RING_BYTES = 3'd1,
      CFG_STS_ENQ    = 3'd2,
      CFG_DESC_ENQ   = 3'd3,
      CFG_MAX_LEN    = 3'd4
   } cfg_sel_e;

   localparam int unsigned ENTRY_BYTES = 8;
   localparam int unsigned LEN_W       = 16;
   localparam int unsigned IDX_FIELD_W = 15;
   localparam int unsigned ENQ_W       = 16;
   localparam int unsigned FLAG_W      = 7;

   typedef struct packed {
      logic crc_in;
      logic rx_err;
      logic overrun;
      logic framing;
      logic runt;
      logic extra;
      logic crc_err;
   } rx_flags_t;
endpackage

// File: rtl/rsq_credit.sv
module rsq_credit #(
   parameter int unsigned CNT_W = 7,
   parameter int unsigned ENQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic             add_en,
   input  logic [ENQ_W-1:0] add_val,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             avail
);
   localparam int unsigned SUM_W = ((ENQ_W > CNT_W) ? ENQ_W : CNT_W) + 2;

   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] cnt_next;

   always_comb begin
      sum = SUM_W'(cnt) - SUM_W'(take) + (add_en ? SUM_W'(add_val) : '0);
      if (clr)
         cnt_next = '0;
      else if (sum > SUM_W'(limit))
         cnt_next = limit;
      else
         cnt_next = CNT_W'(sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_next;
   end

   assign avail = (cnt != '0);

   // Shared by status (R5) and descriptor (R6) pools
   assert_no_take_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cnt != '0));
   assert_pool_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (cnt == '0));
endmodule

// File: rtl/rsq_ring_ptr.sv
module rsq_ring_ptr #(
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   input  logic [IDX_W:0]    ents,
   input  logic [ADDR_W-1:0] base,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] slot_addr
);
   localparam int unsigned SHIFT = $clog2(rsq_pkg::ENTRY_BYTES);

   logic [IDX_W:0] idx_inc;

   always_comb idx_inc = {1'b0, idx} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (restart)
         idx <= '0;
      else if (adv)
         idx <= (idx_inc == ents) ? '0 : idx_inc[IDX_W-1:0];
   end

   assign slot_addr = base + (ADDR_W'(idx) << SHIFT);

   assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, idx} < ents));
endmodule

// File: rtl/rsq_entry_fmt.sv
module rsq_entry_fmt #(
   parameter int unsigned IDX_W             = 6,
   parameter bit          OVERSIZE_AS_EXTRA = 1'b1
) (
   input  logic [rsq_pkg::LEN_W-1:0]  len,
   input  rsq_pkg::rx_flags_t         flags,
   input  logic [rsq_pkg::LEN_W-1:0]  max_len,
   input  logic [IDX_W-1:0]           idx,
   output logic [31:0]                word0,
   output logic [31:0]                word1
);
   logic       too_long;
   logic [5:0] err;
   logic [rsq_pkg::IDX_FIELD_W-1:0] idx_f;

   assign too_long = (len > max_len);
   assign idx_f    = rsq_pkg::IDX_FIELD_W'(idx);

   generate
      if (OVERSIZE_AS_EXTRA) begin : g_over_extra
         assign err = {flags.rx_err, flags.overrun, flags.framing, flags.runt,
                       flags.extra | too_long, flags.crc_err};
      end else begin : g_over_rxerr
         assign err = {flags.rx_err | too_long, flags.overrun, flags.framing,
                       flags.runt, flags.extra, flags.crc_err};
      end
   endgenerate

   always_comb begin
      word0        = '0;
      word0[31]    = 1'b1;
      word0[30]    = ~|err;
      word0[29]    = 1'b1;
      word0[28]    = 1'b1;
      word0[21:16] = err;
      word0[15]    = flags.crc_in;
      word1        = {1'b1, idx_f, len};
   end
endmodule

// File: rtl/rx_status_writer.sv
module rx_status_writer #(
   parameter int unsigned ADDR_W            = 32,
   parameter int unsigned MAX_ENTRIES       = 64,
   parameter int unsigned DEF_MAX_LEN       = 2044,
   parameter bit          OVERSIZE_AS_EXTRA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fd_valid,
   input  logic [15:0]       fd_len,
   input  logic [6:0]        fd_flags,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              irq_ack,
   output logic              irq_pend,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [63:0]       mem_wdata
);
   import rsq_pkg::*;

   localparam int unsigned IDX_W = $clog2(MAX_ENTRIES);
   localparam int unsigned ENT_W = IDX_W + 1;
   localparam int unsigned NPOOL = 2;

   initial begin
      assert (MAX_ENTRIES >= 2 && (MAX_ENTRIES & (MAX_ENTRIES - 1)) == 0)
         else $error("MAX_ENTRIES must be a power of two >= 2");
      assert (IDX_W <= IDX_FIELD_W) else $error("index exceeds status field");
      assert (ADDR_W >= 4 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (DEF_MAX_LEN < 65536) else $error("DEF_MAX_LEN exceeds field");
   end

   logic [ADDR_W-1:0] base_q;
   logic [ENT_W-1:0]  ents_q;
   logic [LEN_W-1:0]  maxlen_q;
   logic [31:0]       ents_raw;
   logic              restart;
   logic              take;
   logic [NPOOL-1:0]  pool_avail;
   logic [ENT_W-1:0]  pool_cnt [NPOOL];
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] slot_addr;
   logic [31:0]       w0, w1;

   assign ents_raw = cfg_wdata >> $clog2(ENTRY_BYTES);
   assign restart  = cfg_we && (cfg_sel == CFG_BASE || cfg_sel == CFG_RING_BYTES);
   assign take     = fd_valid && (&pool_avail);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         ents_q   <= ENT_W'(MAX_ENTRIES);
         maxlen_q <= LEN_W'(DEF_MAX_LEN);
      end else if (cfg_we) begin
         case (cfg_sel)
            CFG_BASE:       base_q   <= cfg_wdata[ADDR_W-1:0];
            CFG_RING_BYTES: ents_q   <= (ents_raw == 0 || ents_raw > MAX_ENTRIES) ?
                                        ENT_W'(MAX_ENTRIES) : ENT_W'(ents_raw);
            CFG_MAX_LEN:    maxlen_q <= cfg_wdata[LEN_W-1:0];
            default: ;
         endcase
      end
   end

   // Pool 0: status slots, pool 1: receive descriptors
   generate
      for (genvar p = 0; p < NPOOL; p++) begin : g_pool
         localparam cfg_sel_e ENQ_SEL = (p == 0) ? CFG_STS_ENQ : CFG_DESC_ENQ;
         rsq_credit #(.CNT_W(ENT_W), .ENQ_W(ENQ_W)) u_credit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (restart),
            .take    (take),
            .add_en  (cfg_we && cfg_sel == ENQ_SEL),
            .add_val (cfg_wdata[ENQ_W-1:0]),
            .limit   (ents_q),
            .cnt     (pool_cnt[p]),
            .avail   (pool_avail[p])
         );
      end
   endgenerate

   rsq_ring_ptr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .adv       (take),
      .ents      (ents_q),
      .base      (base_q),
      .idx       (idx),
      .slot_addr (slot_addr)
   );

   rsq_entry_fmt #(.IDX_W(IDX_W), .OVERSIZE_AS_EXTRA(OVERSIZE_AS_EXTRA)) u_fmt (
      .len     (fd_len),
      .flags   (rx_flags_t'(fd_flags)),
      .max_len (maxlen_q),
      .idx     (idx),
      .word0   (w0),
      .word1   (w1)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         irq_pend  <= 1'b0;
      end else begin
         mem_we <= take;
         if (take) begin
            mem_addr  <= slot_addr;
            mem_wdata <= {w1, w0};
         end
         if (take)         irq_pend <= 1'b1;
         else if (irq_ack) irq_pend <= 1'b0;
      end
   end

   assert_both_words_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata[31] && mem_wdata[63]));
   assert_clean_bit_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata[30] == (mem_wdata[21:16] == 6'd0)));
   assert_irq_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> irq_pend);
   assert_write_follows_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(fd_valid));
   assert_slot_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[2:0] == base_q[2:0] || $past(restart)));
endmodule

// File: tb/rx_status_writer_bench.sv
module rx_status_writer_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fd_valid = 1'b0;
   logic [15:0] fd_len = '0;
   logic [6:0]  fd_flags = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        irq_ack = 1'b0;
   logic        irq_pend, mem_we;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_status_writer u_rx_status_writer (
      .clk(clk), .rst_n(rst_n), .fd_valid(fd_valid), .fd_len(fd_len),
      .fd_flags(fd_flags), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .irq_pend(irq_pend),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   // Behavioural reference
   longint m_base, m_ents, m_max, m_idx, m_sc, m_dc, m_raw;
   bit     m_we, m_irq, m_tk;
   logic [31:0] m_addr, m_w0, m_w1;
   logic [5:0]  m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_base = 0; m_ents = 64; m_max = 2044; m_idx = 0; m_sc = 0; m_dc = 0;
         m_we = 0; m_irq = 0;
      end else begin
         m_tk = fd_valid && m_sc > 0 && m_dc > 0;
         if (m_tk) begin
            m_addr = 32'(m_base + m_idx * 8);
            m_err  = fd_flags[5:0];
            if (fd_len > m_max) m_err[1] = 1'b1;
            m_w0 = 32'h3000_0000 | 32'h8000_0000 | (32'(m_err) << 16) | (32'(fd_flags[6]) << 15);
            if (m_err == 0) m_w0 |= 32'h4000_0000;
            m_w1 = 32'h8000_0000 | (32'(m_idx) << 16) | 32'(fd_len);
            m_idx = (m_idx + 1) % m_ents;
            m_sc = m_sc - 1; m_dc = m_dc - 1;
         end
         m_we = m_tk;
         if (m_tk) m_irq = 1; else if (irq_ack) m_irq = 0;
         if (cfg_we && cfg_sel == 3'd2) m_sc += cfg_wdata[15:0];
         if (cfg_we && cfg_sel == 3'd3) m_dc += cfg_wdata[15:0];
         if (m_sc > m_ents) m_sc = m_ents;
         if (m_dc > m_ents) m_dc = m_ents;
         if (cfg_we) begin
            case (cfg_sel)
               3'd0: begin m_base = cfg_wdata; m_idx = 0; m_sc = 0; m_dc = 0; end
               3'd1: begin
                  m_raw = cfg_wdata >> 3;
                  m_ents = (m_raw == 0 || m_raw > 64) ? 64 : m_raw;
                  m_idx = 0; m_sc = 0; m_dc = 0;
               end
               3'd4: m_max = cfg_wdata[15:0];
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(mem_we === m_we, "R5/R6 write strobe", 64'(mem_we), 64'(m_we));
         chk(irq_pend === m_irq, "R9 irq", 64'(irq_pend), 64'(m_irq));
         if (m_we && mem_we) begin
            chk(mem_addr === m_addr, "R4 address", 64'(mem_addr), 64'(m_addr));
            chk(mem_wdata[31:0] === m_w0, "R2 word0", 64'(mem_wdata[31:0]), 64'(m_w0));
            chk(mem_wdata[63:32] === m_w1, "R3 word1", 64'(mem_wdata[63:32]), 64'(m_w1));
         end
      end
   end

   task automatic frame(input logic [15:0] len, input logic [6:0] fl, input bit ack);
      @(negedge clk); #1;
      fd_valid = 1'b1; fd_len = len; fd_flags = fl; irq_ack = ack;
      @(negedge clk); #1;
      fd_valid = 1'b0; irq_ack = 1'b0;
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk); #1;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic burst(input int n);
      @(negedge clk); #1;
      for (int i = 0; i < n; i++) begin
         fd_valid = 1'b1; fd_len = 16'(64 + i * 3); fd_flags = 7'(i);
         @(negedge clk); #1;
      end
      fd_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1: reset state
      chk(mem_we == 1'b0, "R1 mem_we after reset", 64'(mem_we), 64'd0);
      chk(irq_pend == 1'b0, "R1 irq after reset", 64'(irq_pend), 64'd0);
      // R1/R5: no credits yet -> dropped
      frame(16'd80, 7'd0, 1'b0);
      chk(mem_we == 1'b0, "R5 no status credit", 64'(mem_we), 64'd0);
      cfg(3'd2, 32'd4);
      frame(16'd80, 7'd0, 1'b0);
      chk(mem_we == 1'b0, "R6 no descriptor credit", 64'(mem_we), 64'd0);
      cfg(3'd3, 32'd4);
      frame(16'd100, 7'd0, 1'b0);
      chk(mem_we == 1'b1, "R10 write one cycle after event", 64'(mem_we), 64'd1);
      chk(mem_wdata[30] == 1'b1, "R8 clean frame", 64'(mem_wdata[30]), 64'd1);
      chk(mem_addr == 32'd0, "R1 first slot at base 0", 64'(mem_addr), 64'd0);
      frame(16'd2045, 7'd0, 1'b0);
      chk(mem_wdata[17] == 1'b1 && mem_wdata[30] == 1'b0, "R7 oversize flagged",
          64'(mem_wdata[31:0]), 64'h0);
      frame(16'd2044, 7'd0, 1'b0);
      chk(mem_wdata[30] == 1'b1, "R7 length equal max", 64'(mem_wdata[31:0]), 64'h0);
      frame(16'd60, 7'b1000100, 1'b0);
      chk(mem_wdata[18] == 1'b1 && mem_wdata[30] == 1'b0 && mem_wdata[15] == 1'b1,
          "R8 runt clears clean bit", 64'(mem_wdata[31:0]), 64'h0);
      // R9: ack alone clears
      @(negedge clk); #1; irq_ack = 1'b1;
      @(negedge clk); #1; irq_ack = 1'b0;
      chk(irq_pend == 1'b0, "R9 ack clears", 64'(irq_pend), 64'd0);
      // R11: base rewrite empties pools and restarts slot
      cfg(3'd2, 32'd8); cfg(3'd3, 32'd8);
      cfg(3'd0, 32'h0000_1000);
      frame(16'd70, 7'd0, 1'b0);
      chk(mem_we == 1'b0, "R11 credits emptied", 64'(mem_we), 64'd0);
      cfg(3'd1, 32'd32);
      cfg(3'd2, 32'd10); cfg(3'd3, 32'd10);
      frame(16'd70, 7'd0, 1'b1);
      chk(mem_addr == 32'h1000 && mem_wdata[62:48] == 15'd0, "R11 restart at slot 0",
          64'(mem_addr), 64'h1000);
      chk(irq_pend == 1'b1, "R9 write beats ack", 64'(irq_pend), 64'd1);
      burst(5);
      cfg(3'd2, 32'd3); cfg(3'd3, 32'd1);
      burst(3);
      cfg(3'd3, 32'd5);
      burst(4);
      cfg(3'd4, 32'd100);
      cfg(3'd2, 32'd4); cfg(3'd3, 32'd4);
      frame(16'd101, 7'd0, 1'b0);
      chk(mem_wdata[17] == 1'b1, "R7 programmed max exceeded", 64'(mem_wdata[31:0]), 64'h0);
      frame(16'd100, 7'd0, 1'b0);
      chk(mem_wdata[30] == 1'b1, "R7 programmed max equal", 64'(mem_wdata[31:0]), 64'h0);
      cfg(3'd1, 32'd0);
      cfg(3'd2, 32'd100); cfg(3'd3, 32'd100);
      burst(70);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule